// File: doc/BRIEF.md
# Window Watchdog Comparator for Conversion Results

This block watches the stream of converter results as they complete and raises a flag when one falls outside a programmed window. Each result arrives with its channel number, a bit that marks it as a regular or an injected result, and a one-cycle valid strobe. The result is compared in raw form, before any alignment or offset is applied. The thresholds are given as raw values at the converter width.

Watching can be switched on for regular results, injected results, or both. It can also be narrowed to one selected channel number. That one channel number applies to both groups. A hit sets a sticky status flag, which stays set until software pulses a clear. An interrupt line follows the flag while the interrupt enable is set.

Top module: `awd_window_watch`

## Requirements
- R1: After reset, `flag_o` and `irq_o` are 0.
- R2: A watched result strictly greater than `thr_hi` sets `flag_o` one cycle after the strobe. A result equal to `thr_hi` does not set it.
- R3: A watched result strictly less than `thr_lo` sets `flag_o` one cycle after the strobe. A result equal to `thr_lo` does not set it.
- R4: A result with `res_inj`=0 (regular) is watched only while `watch_reg_en`=1. A result with `res_inj`=1 (injected) is watched only while `watch_inj_en`=1. With both enables at 0, the flag never sets.
- R5: With `single_en`=1, only results whose `res_chan` equals `sel_chan` are watched. With `single_en`=0, every channel is watched.
- R6: In single-channel mode with both group enables set, the same `sel_chan` selects the watched channel for regular and for injected results.
- R7: `flag_o` is sticky. A later result inside the window, or no result, leaves it at 1.
- R8: A `flag_clr` pulse clears `flag_o` one cycle later. A violation in the same cycle as the clear wins, and the flag stays 1.
- R9: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en` is 1.
- R10: A cycle with `res_valid`=0 never sets the flag, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_data | input | 12 | Raw conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_inj | input | 1 | 1 = injected result, 0 = regular result |
| thr_hi | input | 12 | Upper window bound (raw value) |
| thr_lo | input | 12 | Lower window bound (raw value) |
| watch_reg_en | input | 1 | Watch regular results |
| watch_inj_en | input | 1 | Watch injected results |
| single_en | input | 1 | Restrict watching to `sel_chan` |
| sel_chan | input | 5 | Channel watched in single-channel mode |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software clear of the status flag |
| flag_o | output | 1 | Sticky out-of-window status |
| irq_o | output | 1 | Interrupt request |

## Verification
A strobed result, or a clear, changes `flag_o` at the first rising edge after it is driven. `irq_o` follows the flag and `irq_en` with no extra register.

The driver applies inputs on the falling edge and records the flag and interrupt values it expects after the next rising edge. The monitor reads the outputs two nanoseconds after each rising edge, so each recorded value is compared in exactly the cycle it is due.

Configuration changes are applied only after that sample has been taken. This keeps the expected value for a cycle from picking up a later setting.

// File: rtl/awd_pkg.sv
// Shared widths and types for the window watchdog.
package awd_pkg;
    localparam int DATA_W = 12;
    localparam int CHAN_W = 5;

    // Result of the window comparison for one sample.
    typedef struct packed {
        logic above;
        logic below;
    } win_res_t;
endpackage

// File: rtl/awd_chan_filter.sv
// Decides whether a strobed result is watched.
// Assumes: the group and channel enables are stable around the strobe.
module awd_chan_filter #(
    parameter int CHAN_W = 5
) (
    input  logic              valid_i,
    input  logic              inj_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  logic              reg_en_i,
    input  logic              inj_en_i,
    input  logic              single_i,
    input  logic [CHAN_W-1:0] sel_i,
    output logic              watch_o
);
    logic group_ok;
    logic chan_ok;

    // Group gate and channel gate combined with the strobe.
    always_comb begin
        group_ok = inj_i ? inj_en_i : reg_en_i;
        chan_ok  = !single_i || (chan_i == sel_i);
        watch_o  = valid_i && group_ok && chan_ok;
    end
endmodule

// File: rtl/awd_window_cmp.sv
// Strict window comparison on the raw, unaligned result.
// Assumes: thresholds are given at the converter width.
module awd_window_cmp
    import awd_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] hi_i,
    input  logic [DW-1:0] lo_i,
    output win_res_t      res_o
);
    // Strict compares: equal to a bound is inside the window.
    always_comb begin
        res_o.above = data_i > hi_i;
        res_o.below = data_i < lo_i;
    end
endmodule

// File: rtl/awd_status.sv
// Sticky status flag with software clear; a new hit wins over a clear.
// Assumes: synchronous active-low reset.
module awd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    // Flag register: set by a hit, cleared by software, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (hit_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // Interrupt is the flag gated by the enable.
    always_comb irq_o = flag_o && irq_en_i;

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> !flag_o);
endmodule

// File: rtl/awd_window_watch.sv
// Top: filters strobed results by group and channel, compares against the
// window, and keeps a sticky flag plus interrupt.
// Assumes: one result per strobe; alignment and offsets are applied elsewhere.
module awd_window_watch
    import awd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic [CW-1:0] res_chan,
    input  logic          res_inj,
    input  logic [DW-1:0] thr_hi,
    input  logic [DW-1:0] thr_lo,
    input  logic          watch_reg_en,
    input  logic          watch_inj_en,
    input  logic          single_en,
    input  logic [CW-1:0] sel_chan,
    input  logic          irq_en,
    input  logic          flag_clr,
    output logic          flag_o,
    output logic          irq_o
);
    logic     watched;
    win_res_t win;
    logic     hit;

    awd_chan_filter #(.CHAN_W(CW)) u_filter (
        .valid_i (res_valid),
        .inj_i   (res_inj),
        .chan_i  (res_chan),
        .reg_en_i(watch_reg_en),
        .inj_en_i(watch_inj_en),
        .single_i(single_en),
        .sel_i   (sel_chan),
        .watch_o (watched)
    );

    awd_window_cmp #(.DW(DW)) u_cmp (
        .data_i(res_data),
        .hi_i  (thr_hi),
        .lo_i  (thr_lo),
        .res_o (win)
    );

    // A hit is a watched result outside the window.
    always_comb hit = watched && (win.above || win.below);

    awd_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .clr_i   (flag_clr),
        .irq_en_i(irq_en),
        .flag_o  (flag_o),
        .irq_o   (irq_o)
    );

    a_r2_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_o);
    a_r4_no_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (!watch_reg_en && !watch_inj_en && !flag_o) |=> !flag_o);
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !flag_o) |=> !flag_o);
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_o);
endmodule

// File: tb/awd_window_watch_bench.sv
module awd_window_watch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        res_inj = 1'b0;
    logic [11:0] thr_hi = 12'hC00;
    logic [11:0] thr_lo = 12'h100;
    logic        watch_reg_en = 1'b1;
    logic        watch_inj_en = 1'b0;
    logic        single_en = 1'b0;
    logic [4:0]  sel_chan = '0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        flag_o;
    logic        irq_o;

    int checks = 0;
    int fails = 0;
    logic model_flag = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic  f;
        logic  i;
        string req;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    awd_window_watch u_awd_window_watch (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_inj(res_inj), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .watch_reg_en(watch_reg_en), .watch_inj_en(watch_inj_en),
        .single_en(single_en), .sel_chan(sel_chan), .irq_en(irq_en),
        .flag_clr(flag_clr), .flag_o(flag_o), .irq_o(irq_o)
    );

    // Driver: one cycle of stimulus, the model update and the expected item.
    task automatic apply(input logic v, input logic [11:0] d, input logic [4:0] ch,
                         input logic inj, input logic clr, input string req);
        logic grp, chok, viol;
        @(negedge clk);
        res_valid = v; res_data = d; res_chan = ch; res_inj = inj; flag_clr = clr;
        grp  = inj ? watch_inj_en : watch_reg_en;
        chok = !single_en || (ch == sel_chan);
        viol = v && grp && chok && ((d > thr_hi) || (d < thr_lo));
        model_flag = viol ? 1'b1 : (clr ? 1'b0 : model_flag);
        q.push_back('{f: model_flag, i: model_flag && irq_en, req: req});
        @(posedge clk);
        #3;
    endtask

    // Monitor: compares outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (flag_o !== e.f || irq_o !== e.i) begin
                fails++;
                $display("FAIL %s: flag/irq actual %b/%b expected %b/%b",
                         e.req, flag_o, irq_o, e.f, e.i);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (flag_o !== 1'b0 || irq_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: flag/irq actual %b/%b expected 0/0", flag_o, irq_o);
        end
        apply(1'b0, 12'hFFF, 5'd0, 1'b0, 1'b0, "R10 no strobe");
        apply(1'b1, 12'hC00, 5'd0, 1'b0, 1'b0, "R2 equal hi");
        apply(1'b1, 12'h100, 5'd0, 1'b0, 1'b0, "R3 equal lo");
        apply(1'b1, 12'hC01, 5'd0, 1'b0, 1'b0, "R2 above hi, R9 irq off");
        apply(1'b1, 12'h500, 5'd0, 1'b0, 1'b0, "R7 in window keeps flag");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b0, "R7 idle keeps flag");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b1, "R8 clear");
        apply(1'b1, 12'h0FF, 5'd0, 1'b0, 1'b0, "R3 below lo");
        irq_en = 1'b1;
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b0, "R9 irq on");
        apply(1'b1, 12'hFFF, 5'd0, 1'b0, 1'b1, "R8 hit wins over clear");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b1, "R8 clear again");
        watch_reg_en = 1'b0; watch_inj_en = 1'b1;
        apply(1'b1, 12'hFFF, 5'd0, 1'b0, 1'b0, "R4 regular ignored");
        apply(1'b1, 12'hFFF, 5'd0, 1'b1, 1'b0, "R4 injected watched");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b1, "R4 clear");
        watch_inj_en = 1'b0;
        apply(1'b1, 12'hFFF, 5'd0, 1'b1, 1'b0, "R4 both off injected");
        apply(1'b1, 12'h000, 5'd0, 1'b0, 1'b0, "R4 both off regular");
        watch_reg_en = 1'b1; watch_inj_en = 1'b1; single_en = 1'b1; sel_chan = 5'd7;
        apply(1'b1, 12'hFFF, 5'd3, 1'b0, 1'b0, "R5 other channel ignored");
        apply(1'b1, 12'hFFF, 5'd7, 1'b0, 1'b0, "R5 selected channel");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b1, "R5 clear");
        apply(1'b1, 12'h000, 5'd7, 1'b1, 1'b0, "R6 injected same channel");
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b1, "R6 clear");
        apply(1'b1, 12'h000, 5'd3, 1'b1, 1'b0, "R6 injected other channel");
        single_en = 1'b0;
        apply(1'b1, 12'hFFF, 5'd3, 1'b0, 1'b0, "R5 all channels");
        irq_en = 1'b0;
        apply(1'b0, 12'h000, 5'd0, 1'b0, 1'b0, "R9 irq disabled");
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule